// File: doc/BRIEF.md
# Oversampled Type B Character Receiver

This block turns a demodulated one-bit line, sampled four times per elementary time unit (etu), into the bytes of a Type B frame. It hunts for a start-of-frame made of a long low stretch followed by a high level. It then collects characters of ten etus each: a low start bit, eight data bits sent least significant first, and a high stop bit. A character whose ten bits are all low marks the end of the frame. Each recovered byte leaves on a write port together with its position in the frame. A completed frame produces a one-cycle done pulse carrying the byte count. A frame that breaks down produces a one-cycle error pulse.

The line is sampled on every clock. Inside the start-of-frame and character states a phase counter steps 0 to 3 and the line is judged when that counter reaches 2, which is the middle of an etu. While waiting for a start bit, the same counter measures the length of the high gap. CRC checking and command decoding are left to the logic downstream. The reset is synchronous.

States and transitions: HUNT (unsynced) goes to SOF_LOW on any low sample. SOF_LOW goes to WAIT_START when the start-of-frame qualifies, and back to HUNT when it does not. WAIT_START goes to CHAR on a low sample, and to HUNT (error) when the high gap is too long. CHAR goes back to WAIT_START after a valid byte. It goes to HUNT after an end-of-frame character, after an invalid character (error) or after the last byte the frame may hold (error).

Top module: `typeb_char_rx`

## Requirements
- R1: A synchronous reset puts the block in HUNT and drives byte_we_o, done_o and err_o low. A reset in the middle of a character discards that character.
- R2: Start-of-frame is judged every 4 samples, at 2, 6, 10, … samples after the first low sample. It is accepted when a high judgement follows 10 or 11 low judgements. Fewer than 10, or 12 or more, low judgements send the block back to HUNT silently: no error and no output.
- R3: A character is a low start bit, 8 data bits sent LSB first and a high stop bit, each 4 samples long and judged at phase 2. A valid character gives a one-cycle byte_we_o pulse with byte_data_o. This pulse comes in the cycle after the stop bit is judged, and byte_idx_o counts 0, 1, 2, … within the frame.
- R4: After the stop bit is judged (or the high judgement of the start-of-frame), up to 25 further high samples may come before the first low sample of the next start bit. The 26th high sample gives an err_o pulse and the block returns to HUNT.
- R5: An all-low character (start, data and stop bits all low) after at least one byte gives a one-cycle done_o pulse. done_cnt_o then equals the number of bytes in the frame, and no byte is written.
- R6: An all-low character straight after start-of-frame, with no byte received, returns the block to HUNT with no done_o and no err_o.
- R7: A character whose stop bit is judged low while some other bit is high is rejected. No byte is written, err_o pulses and the block returns to HUNT.
- R8: The MAX_BYTES-th byte of a frame (default 16) is still written. It is followed by an err_o pulse and a return to HUNT, so later characters of that frame are not written.
- R9: done_o and err_o are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Demodulated line sample, four per etu |
| byte_we_o | output | 1 | One-cycle strobe for a received byte |
| byte_data_o | output | 8 | Received data byte |
| byte_idx_o | output | CNT_W (5) | Position of the byte within the frame |
| done_o | output | 1 | One-cycle pulse for a completed frame |
| done_cnt_o | output | CNT_W (5) | Number of bytes in the completed frame |
| err_o | output | 1 | One-cycle pulse when a frame in progress is aborted |

## Verification
The embedded assertions check on every cycle the invariants of the state machine. The phase counter stays below four inside a character, and the gap counter never passes its limit while waiting for a start bit. Completion and error pulses never coincide, and each leaves the block in HUNT. Byte strobes are never back to back, a completed frame never reports zero bytes, and the start-of-frame evaluation count stays within its bound.

Only the bench scenarios can show the decoded content. These cover byte values and their order, the exact start-of-frame acceptance window (9, 10, 11 and 12 low etus), the 24 and 25 sample gap boundary, the silent empty frame, rejected stop bits, truncation at the maximum length and reset in the middle of a character. Random frames vary the lengths, gaps and start-of-frame shapes.

// File: rtl/typeb_rx_pkg.sv
package typeb_rx_pkg;
    localparam int DATA_W = 8;
    localparam int CHAR_W = DATA_W + 2;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_SOF_LOW,
        RX_WAIT_START,
        RX_CHAR
    } rx_state_e;
endpackage

// File: rtl/typeb_rx_count.sv
module typeb_rx_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/typeb_rx_shift10.sv
module typeb_rx_shift10
    import typeb_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              bit_i,
    output logic              ok_nxt_o,
    output logic              eof_nxt_o,
    output logic [DATA_W-1:0] byte_nxt_o
);
    logic [CHAR_W-1:0] word_q;
    logic [CHAR_W-1:0] word_nxt;

    // New bit enters at the top, older bits move toward bit 0
    assign word_nxt   = {bit_i, word_q[CHAR_W-1:1]};
    assign ok_nxt_o   = word_nxt[CHAR_W-1] && !word_nxt[0];
    assign eof_nxt_o  = (word_nxt == '0);
    assign byte_nxt_o = word_nxt[CHAR_W-2:1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word_q <= '0;
        end else if (en) begin
            word_q <= word_nxt;
        end
    end
endmodule

// File: rtl/typeb_char_rx.sv
module typeb_char_rx
    import typeb_rx_pkg::*;
#(
    parameter int SPE         = 4,
    parameter int SOF_MIN_LOW = 10,
    parameter int SOF_MAX_LOW = 12,
    parameter int GAP_MAX     = 25,
    parameter int MAX_BYTES   = 16,
    localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic              byte_we_o,
    output logic [DATA_W-1:0] byte_data_o,
    output logic [CNT_W-1:0]  byte_idx_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  done_cnt_o,
    output logic              err_o
);
    localparam int POS_LIM = (GAP_MAX > SPE) ? GAP_MAX : SPE;
    localparam int POS_W   = $clog2(POS_LIM + 2);
    localparam int BIT_LIM = (SOF_MAX_LOW > CHAR_W) ? SOF_MAX_LOW : CHAR_W;
    localparam int BIT_W   = $clog2(BIT_LIM + 2);
    localparam logic [POS_W-1:0] EVAL_PH  = POS_W'(SPE / 2);
    localparam logic [POS_W-1:0] SPE_L    = POS_W'(SPE);
    localparam logic [POS_W-1:0] GAP_L    = POS_W'(GAP_MAX);
    localparam logic [BIT_W-1:0] SMIN_L   = BIT_W'(SOF_MIN_LOW);
    localparam logic [BIT_W-1:0] SMAX_L   = BIT_W'(SOF_MAX_LOW);
    localparam logic [BIT_W-1:0] CHBITS_L = BIT_W'(CHAR_W);
    localparam logic [CNT_W-1:0] MAXB_L   = CNT_W'(MAX_BYTES);

    rx_state_e st_q, st_d;

    logic [POS_W-1:0] pos_q, pos_nxt;
    logic [BIT_W-1:0] bit_q, bit_nxt;
    logic [CNT_W-1:0] byt_q, byt_nxt;
    logic pos_clr, pos_inc, bit_clr, bit_inc, byt_clr, byt_inc;
    logic sh_clr, sh_en;
    logic ok_nxt, eof_nxt;
    logic [DATA_W-1:0] byte_nxt;
    logic eval, wrap;
    logic we_d, done_d, err_d;

    typeb_rx_count #(.W(POS_W)) u_pos (
        .clk(clk), .rst(rst), .clr(pos_clr), .inc(pos_inc), .cnt(pos_q)
    );
    typeb_rx_count #(.W(BIT_W)) u_bits (
        .clk(clk), .rst(rst), .clr(bit_clr), .inc(bit_inc), .cnt(bit_q)
    );
    typeb_rx_count #(.W(CNT_W)) u_bytes (
        .clk(clk), .rst(rst), .clr(byt_clr), .inc(byt_inc), .cnt(byt_q)
    );
    typeb_rx_shift10 u_shift (
        .clk(clk), .rst(rst), .clr(sh_clr), .en(sh_en), .bit_i(line_i),
        .ok_nxt_o(ok_nxt), .eof_nxt_o(eof_nxt), .byte_nxt_o(byte_nxt)
    );

    assign pos_nxt = pos_q + 1'b1;
    assign bit_nxt = bit_q + 1'b1;
    assign byt_nxt = byt_q + 1'b1;
    assign eval    = (pos_nxt == EVAL_PH);
    assign wrap    = (pos_nxt >= SPE_L);

    // Next state and control
    always_comb begin
        st_d    = st_q;
        pos_clr = 1'b0;
        pos_inc = 1'b0;
        bit_clr = 1'b0;
        bit_inc = 1'b0;
        byt_clr = 1'b0;
        byt_inc = 1'b0;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        we_d    = 1'b0;
        done_d  = 1'b0;
        err_d   = 1'b0;
        unique case (st_q)
            RX_HUNT: begin
                if (!line_i) begin
                    st_d    = RX_SOF_LOW;
                    pos_clr = 1'b1;
                    bit_clr = 1'b1;
                end
            end
            RX_SOF_LOW: begin
                pos_inc = 1'b1;
                if (wrap) pos_clr = 1'b1;
                if (eval) begin
                    bit_inc = 1'b1;
                    if (bit_nxt > SMAX_L) begin
                        st_d = RX_HUNT;
                    end else if (line_i) begin
                        if (bit_q >= SMIN_L) begin
                            st_d    = RX_WAIT_START;
                            pos_clr = 1'b1;
                            byt_clr = 1'b1;
                        end else begin
                            st_d = RX_HUNT;
                        end
                    end
                end
            end
            RX_WAIT_START: begin
                pos_inc = 1'b1;
                if (line_i) begin
                    if (pos_nxt > GAP_L) begin
                        st_d  = RX_HUNT;
                        err_d = 1'b1;
                    end
                end else begin
                    st_d    = RX_CHAR;
                    pos_clr = 1'b1;
                    bit_clr = 1'b1;
                    sh_clr  = 1'b1;
                end
            end
            RX_CHAR: begin
                pos_inc = 1'b1;
                if (wrap) pos_clr = 1'b1;
                if (eval) begin
                    sh_en   = 1'b1;
                    bit_inc = 1'b1;
                    if (bit_nxt == CHBITS_L) begin
                        if (ok_nxt) begin
                            we_d    = 1'b1;
                            byt_inc = 1'b1;
                            if (byt_nxt >= MAXB_L) begin
                                st_d  = RX_HUNT;
                                err_d = 1'b1;
                            end else begin
                                st_d    = RX_WAIT_START;
                                pos_clr = 1'b1;
                            end
                        end else if (eof_nxt) begin
                            st_d   = RX_HUNT;
                            done_d = (byt_q != '0);
                        end else begin
                            st_d  = RX_HUNT;
                            err_d = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= RX_HUNT;
        else     st_q <= st_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_we_o   <= 1'b0;
            byte_data_o <= '0;
            byte_idx_o  <= '0;
            done_o      <= 1'b0;
            done_cnt_o  <= '0;
            err_o       <= 1'b0;
        end else begin
            byte_we_o <= we_d;
            done_o    <= done_d;
            err_o     <= err_d;
            if (we_d) begin
                byte_data_o <= byte_nxt;
                byte_idx_o  <= byt_q;
            end
            if (done_d) done_cnt_o <= byt_q;
        end
    end

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
    // R9
    err_to_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (st_q == RX_HUNT));
    // R5
    done_to_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (st_q == RX_HUNT && done_cnt_o != '0));
    // R4
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_WAIT_START) |-> (pos_q <= GAP_L));
    // R3
    char_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_CHAR) |-> (pos_q < SPE_L));
    // R3
    we_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        byte_we_o |=> !byte_we_o);
    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        byte_we_o |-> (byte_idx_o < MAXB_L));
    // R2
    sof_count_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_SOF_LOW) |-> (bit_q <= SMAX_L));
endmodule

// File: tb/test_typeb_char_rx.sv
module test_typeb_char_rx;
    localparam int MAXB  = 16;
    localparam int CNT_W = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             line_i = 1'b1;
    logic             byte_we_o;
    logic [7:0]       byte_data_o;
    logic [CNT_W-1:0] byte_idx_o;
    logic             done_o;
    logic [CNT_W-1:0] done_cnt_o;
    logic             err_o;

    always #5 clk = ~clk;

    typeb_char_rx #(.MAX_BYTES(MAXB)) i_typeb_char_rx (
        .clk(clk), .rst(rst), .line_i(line_i),
        .byte_we_o(byte_we_o), .byte_data_o(byte_data_o),
        .byte_idx_o(byte_idx_o), .done_o(done_o),
        .done_cnt_o(done_cnt_o), .err_o(err_o)
    );

    int checks = 0;
    int fails  = 0;

    // Observed events, cleared between frames
    logic [7:0] got_d [64];
    int         got_i [64];
    int         n_we   = 0;
    int         n_done = 0;
    int         n_err  = 0;
    int         last_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_we_o && n_we < 64) begin
                got_d[n_we] = byte_data_o;
                got_i[n_we] = int'(byte_idx_o);
                n_we = n_we + 1;
            end
            if (done_o) begin
                n_done = n_done + 1;
                last_cnt = int'(done_cnt_o);
            end
            if (err_o) n_err = n_err + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic b, input int n);
        for (int k = 0; k < n; k++) begin
            line_i = b;
            @(negedge clk);
        end
    endtask

    task automatic send_sof(input int lows, input int highs);
        put(1'b0, 4 * lows);
        put(1'b1, highs);
    endtask

    task automatic send_char(input logic [7:0] d, input logic stop, input int gap);
        put(1'b0, 4);
        for (int i = 0; i < 8; i++) put(d[i], 4);
        put(stop, 4);
        put(1'b1, gap);
    endtask

    task automatic clear_mon();
        n_we = 0; n_done = 0; n_err = 0; last_cnt = 0;
    endtask

    logic [7:0] exp_d [64];

    // Compare collected events with the expected frame outcome
    task automatic judge(input string req, input int nbytes, input int ndone,
                         input int cnt, input int nerr);
        chk({req, " byte count"}, n_we, nbytes);
        for (int i = 0; i < nbytes && i < n_we; i++) begin
            chk({req, " data"}, int'(got_d[i]), int'(exp_d[i]));
            chk({req, " index"}, got_i[i], i);
        end
        chk({req, " done"}, n_done, ndone);
        if (ndone != 0) chk({req, " done count"}, last_cnt, cnt);
        chk({req, " err"}, n_err, nerr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int len, gap, sl, sh;
        void'($urandom(32'd4711));
        line_i = 1'b1;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 reset we", int'(byte_we_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset err", int'(err_o), 0);
        rst = 1'b0;
        put(1'b1, 16);

        // R3 R5: directed short frame, 10 low SOF etus, minimal gap
        clear_mon();
        exp_d[0] = 8'hA5; exp_d[1] = 8'h00; exp_d[2] = 8'hFF;
        send_sof(10, 8);
        for (int i = 0; i < 3; i++) send_char(exp_d[i], 1'b1, 0);
        put(1'b0, 40);
        put(1'b1, 40);
        judge("R3_R5 directed", 3, 1, 3, 0);

        // R2 R4: 11 low etus, longest SOF high, gap 24 everywhere
        clear_mon();
        exp_d[0] = 8'h3C; exp_d[1] = 8'h81;
        send_sof(11, 28);
        for (int i = 0; i < 2; i++) send_char(exp_d[i], 1'b1, 24);
        put(1'b0, 40);
        put(1'b1, 40);
        judge("R2_R4 window edge", 2, 1, 2, 0);

        // R2: 9 low etus is too short
        clear_mon();
        send_sof(9, 8);
        send_char(8'h5A, 1'b1, 0);
        put(1'b1, 60);
        judge("R2 short sof", 0, 0, 0, 0);

        // R2: 12 low etus is too long
        clear_mon();
        send_sof(12, 8);
        send_char(8'h5A, 1'b1, 0);
        put(1'b1, 60);
        judge("R2 long sof", 0, 0, 0, 0);

        // R4: gap of 25 extra high samples aborts
        clear_mon();
        exp_d[0] = 8'h11;
        send_sof(10, 8);
        send_char(8'h11, 1'b1, 25);
        send_char(8'h22, 1'b1, 0);
        put(1'b1, 60);
        judge("R4 gap overrun", 1, 0, 0, 1);

        // R6: empty frame is silent
        clear_mon();
        send_sof(10, 8);
        put(1'b0, 40);
        put(1'b1, 40);
        judge("R6 empty frame", 0, 0, 0, 0);

        // R7: stop bit low on a non-zero character
        clear_mon();
        exp_d[0] = 8'h77;
        send_sof(11, 8);
        send_char(8'h77, 1'b1, 3);
        send_char(8'hA5, 1'b0, 0);
        put(1'b1, 60);
        judge("R7 bad stop", 1, 0, 0, 1);

        // R8: frame longer than the limit is cut after MAXB bytes
        clear_mon();
        for (int i = 0; i < MAXB + 2; i++) exp_d[i] = 8'($urandom);
        send_sof(10, 8);
        for (int i = 0; i < MAXB + 2; i++) send_char(exp_d[i], 1'b1, 2);
        put(1'b1, 60);
        judge("R8 overflow", MAXB, 0, 0, 1);

        // R8 boundary: one less than the limit completes
        clear_mon();
        for (int i = 0; i < MAXB - 1; i++) exp_d[i] = 8'($urandom);
        send_sof(10, 8);
        for (int i = 0; i < MAXB - 1; i++) send_char(exp_d[i], 1'b1, 0);
        put(1'b0, 40);
        put(1'b1, 40);
        judge("R8 limit minus one", MAXB - 1, 1, MAXB - 1, 0);

        // R1: reset in the middle of a character discards it
        clear_mon();
        send_sof(10, 8);
        put(1'b0, 4);
        put(1'b1, 8);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        put(1'b1, 60);
        judge("R1 mid reset", 0, 0, 0, 0);

        // R3 R5 R9: random frames
        for (int f = 0; f < 30; f++) begin
            clear_mon();
            len = 1 + int'($urandom % (MAXB - 1));
            sl  = 10 + int'($urandom % 2);
            sh  = 8 + int'($urandom % 21);
            for (int i = 0; i < len; i++) exp_d[i] = 8'($urandom);
            send_sof(sl, sh);
            for (int i = 0; i < len; i++) begin
                gap = int'($urandom % 25);
                send_char(exp_d[i], 1'b1, gap);
            end
            put(1'b0, 40);
            put(1'b1, 20 + int'($urandom % 20));
            judge("R3_R5_R9 random", len, 1, len, 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule